// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns one pulse-width command into the two gate enables of a synchronous buck power stage: one for the high-side switch and one for the low-side switch. A gate is never switched on straight away. The controller first removes the gate that is currently on. It then waits until a comparator flag reports that this gate has really dropped below its threshold. After that it counts a fixed number of clock cycles and only then enables the other gate. The dead time therefore follows the real gate discharge instead of a worst-case blanking figure.

Two override inputs sit above the command. The clamp input selects the low side through the same interlock, as an over-voltage response would. The kill input drops both gates at once and holds them low. If a fall flag never arrives, a timeout lets the sequence go on anyway and raises a sticky fault. If the command changes while a turn-on is pending, that turn-on is abandoned and the sequence starts again toward the new side. The command may stay high or low for any length of time, so duty runs from 0% to 100%.

Top module: `dtgate_ctrl`

## Requirements
- R1: `hs_on` and `ls_on` are never high in the same cycle.
- R2: A synchronous active-high `rst` clears `hs_on`, `ls_on` and `sense_fault` at the next clock edge.
- R3: While the controller waits to turn on the high side, suppose `ls_fallen` is high (1 = low-side gate below threshold) at clock edge e. Then `hs_on` rises at edge e+DELAY_CYC. It does not rise earlier, and it does not rise while `ls_fallen` stays low before the timeout.
- R4: The low-side turn-on follows the same rule as R3, using `hs_fallen` (1 = high-side gate-to-switch-node voltage below threshold).
- R5: A gate that is on goes low at the first clock edge where the selected side is no longer its own side.
- R6: `force_ls` high selects the low side whatever `pwm_cmd` is. The high side turns off and the low side turns on through the R4 interlock.
- R7: `force_off` high has the highest priority. Both gates are low from the next edge for as long as it is held.
- R8: Suppose the selected side changes while a turn-on is still pending, either in the wait for the fall flag or in the delay count. The pending turn-on is dropped, no gate rises for it, and the R3/R4 sequence restarts toward the new side.
- R9: Suppose the needed fall flag stays low for TIMEOUT_CYC edges of waiting. The sequence then moves on to the delay count as if the flag had arrived, and `sense_fault` goes high. It stays high until reset.
- R10: The side selection is `pwm_cmd`=1 for the high side and 0 for the low side. A steady command keeps the selected gate on for as long as it is held, which covers 100% and 0% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_cmd | input | 1 | Pulse-width command: 1 selects the high side, 0 the low side |
| hs_fallen | input | 1 | High-side gate is below its turn-off threshold |
| ls_fallen | input | 1 | Low-side gate is below its turn-off threshold |
| force_ls | input | 1 | Clamp request: select the low side |
| force_off | input | 1 | Kill request: both gates off |
| hs_on | output | 1 | High-side gate enable, registered |
| ls_on | output | 1 | Low-side gate enable, registered |
| sense_fault | output | 1 | Sticky flag: a fall flag timed out |

## Verification
The bench drives transitions in both directions under two flag timings. In one the flag is already present when the wait begins. In the other the flag is raised several cycles later. The edge on which the new gate rises shows whether the controller waits on the flag and then adds exactly the fixed delay. A command reversal during the delay count must not produce the abandoned edge, which shows that cancel is different from plain completion. A stuck flag exposes the timeout edge and fault timing. Clamp, kill and long steady commands separate override priority from normal switching and confirm that full and zero duty hold without glitches.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [1:0] {SIDE_NONE, SIDE_HS, SIDE_LS} side_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FALL, ST_DLY, ST_ON} st_e;
endpackage

// File: rtl/dtg_cycle_timer.sv
// Counts the cycles spent with run high; done marks the LIMIT-th such cycle.
module dtg_cycle_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign done = run && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (run && !done)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtg_side_select.sv
// Priority: kill, then clamp, then the pulse-width command.
module dtg_side_select
  import dtg_pkg::*;
(
  input  logic  pwm_cmd,
  input  logic  force_ls,
  input  logic  force_off,
  output side_e want
);
  always_comb begin
    if (force_off)     want = SIDE_NONE;
    else if (force_ls) want = SIDE_LS;
    else if (pwm_cmd)  want = SIDE_HS;
    else               want = SIDE_LS;
  end
endmodule

// File: rtl/dtg_sequencer.sv
module dtg_sequencer
  import dtg_pkg::*;
#(
  parameter int DELAY_CYC   = 4,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  side_e want,
  input  logic  hs_fallen,
  input  logic  ls_fallen,
  output logic  hs_on,
  output logic  ls_on,
  output logic  fault
);
  st_e   st_q, st_d;
  side_e tgt_q, tgt_d;
  logic  cancel, sensed, to_done, dly_done, timeout_hit;

  // A pending turn-on is dropped as soon as the wanted side moves away.
  assign cancel = ((st_q == ST_FALL) || (st_q == ST_DLY)) && (want != tgt_q);
  // Turn-on of one side is released by the fall of the opposite gate.
  assign sensed = (tgt_q == SIDE_HS) ? ls_fallen : hs_fallen;

  dtg_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_timeout (
    .clk  (clk),
    .rst  (rst),
    .clr  ((st_q != ST_FALL) || cancel),
    .run  ((st_q == ST_FALL) && !cancel),
    .done (to_done)
  );

  dtg_cycle_timer #(.LIMIT(DELAY_CYC)) u_delay (
    .clk  (clk),
    .rst  (rst),
    .clr  ((st_q != ST_DLY) || cancel),
    .run  ((st_q == ST_DLY) && !cancel),
    .done (dly_done)
  );

  always_comb begin
    st_d        = st_q;
    tgt_d       = tgt_q;
    timeout_hit = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (want != SIDE_NONE) begin
          st_d  = ST_FALL;
          tgt_d = want;
        end
      end
      ST_FALL: begin
        if (cancel) begin
          st_d  = (want == SIDE_NONE) ? ST_IDLE : ST_FALL;
          tgt_d = want;
        end else if (sensed) begin
          st_d = ST_DLY;
        end else if (to_done) begin
          st_d        = ST_DLY;
          timeout_hit = 1'b1;
        end
      end
      ST_DLY: begin
        if (cancel) begin
          st_d  = (want == SIDE_NONE) ? ST_IDLE : ST_FALL;
          tgt_d = want;
        end else if (dly_done) begin
          st_d = ST_ON;
        end
      end
      ST_ON: begin
        if (want != tgt_q) begin
          st_d  = (want == SIDE_NONE) ? ST_IDLE : ST_FALL;
          tgt_d = want;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        tgt_d = SIDE_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      tgt_q <= SIDE_NONE;
      hs_on <= 1'b0;
      ls_on <= 1'b0;
      fault <= 1'b0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      hs_on <= (st_d == ST_ON) && (tgt_d == SIDE_HS);
      ls_on <= (st_d == ST_ON) && (tgt_d == SIDE_LS);
      fault <= fault || timeout_hit;
    end
  end

  // R9: the timeout fault never clears on its own
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault)
    else $error("sense fault dropped without reset");

  // R8: a cancelled wait never ends in a gate edge
  p_cancel_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !$rose(hs_on) && !$rose(ls_on))
    else $error("gate rose on a cancelled turn-on");
endmodule

// File: rtl/dtgate_ctrl.sv
module dtgate_ctrl
  import dtg_pkg::*;
#(
  parameter int DELAY_CYC   = 4,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_cmd,
  input  logic hs_fallen,
  input  logic ls_fallen,
  input  logic force_ls,
  input  logic force_off,
  output logic hs_on,
  output logic ls_on,
  output logic sense_fault
);
  localparam int GW = $clog2(DELAY_CYC + 2);

  side_e want;

  dtg_side_select u_sel (
    .pwm_cmd   (pwm_cmd),
    .force_ls  (force_ls),
    .force_off (force_off),
    .want      (want)
  );

  dtg_sequencer #(
    .DELAY_CYC   (DELAY_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .want      (want),
    .hs_fallen (hs_fallen),
    .ls_fallen (ls_fallen),
    .hs_on     (hs_on),
    .ls_on     (ls_on),
    .fault     (sense_fault)
  );

  // Observation logic for the turn-on gap checks (index 0 high side, 1 low side)
  logic [1:0] gate_v;
  assign gate_v = {ls_on, hs_on};

  for (genvar g = 0; g < 2; g++) begin : g_gap
    logic [GW-1:0] off_run;
    always_ff @(posedge clk) begin
      if (rst || gate_v[1-g])
        off_run <= '0;
      else if (off_run != GW'(DELAY_CYC + 1))
        off_run <= off_run + 1'b1;
    end
    // R3 (g=0) and R4 (g=1): a rise needs the other gate off for the delay
    p_turnon_gap_r3_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_v[g]) |-> off_run >= GW'(DELAY_CYC))
      else $error("gate rose before the dead-time delay");
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on))
    else $error("both gates enabled");

  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> !hs_on && !ls_on && !sense_fault)
    else $error("outputs not cleared by reset");

  p_turnoff_r5: assert property (@(posedge clk) disable iff (rst)
    hs_on && (force_off || force_ls || !pwm_cmd) |=> !hs_on)
    else $error("high side not dropped promptly");

  p_kill_r7: assert property (@(posedge clk) disable iff (rst)
    force_off |=> !hs_on && !ls_on)
    else $error("kill request did not clear gates");
endmodule

// File: tb/dtgate_ctrl_tb.sv
module dtgate_ctrl_tb;
  localparam int DLY = 4;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst, pwm_cmd, hs_fallen, ls_fallen, force_ls, force_off;
  logic hs_on, ls_on, sense_fault;

  typedef struct {
    int    cyc;
    logic  hs;
    logic  ls;
    logic  flt;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  dtgate_ctrl #(.DELAY_CYC(DLY), .TIMEOUT_CYC(TMO)) u_dut (
    .clk (clk), .rst (rst), .pwm_cmd (pwm_cmd),
    .hs_fallen (hs_fallen), .ls_fallen (ls_fallen),
    .force_ls (force_ls), .force_off (force_off),
    .hs_on (hs_on), .ls_on (ls_on), .sense_fault (sense_fault)
  );

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected outputs, off cycles after the current one
  task automatic expect_at(input int off, input logic hs, input logic ls,
                           input logic flt, input string tag);
    exp_t e;
    e.cyc = cyc + off; e.hs = hs; e.ls = ls; e.flt = flt; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor / scoreboard
  initial forever begin
    @(negedge clk);
    #1;
    if (hs_on === 1'b1 && ls_on === 1'b1) begin
      errors++;
      $display("FAIL R1 cycle %0d: hs=%0b ls=%0b expected not both high", cyc, hs_on, ls_on);
    end
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc || hs_on !== e.hs || ls_on !== e.ls || sense_fault !== e.flt) begin
        errors++;
        $display("FAIL %s cycle %0d: got hs=%0b ls=%0b flt=%0b expected hs=%0b ls=%0b flt=%0b",
                 e.tag, cyc, hs_on, ls_on, sense_fault, e.hs, e.ls, e.flt);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: got hung run expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; force_off = 1'b1; force_ls = 1'b0; pwm_cmd = 1'b0;
    hs_fallen = 1'b1; ls_fallen = 1'b1;
    tick(3);
    rst = 1'b0;
    expect_at(1, 0, 0, 0, "R2 reset state");
    expect_at(2, 0, 0, 0, "R7 kill holds idle");
    tick(3);

    // Low side from idle, flag already present
    force_off = 1'b0;
    expect_at(DLY + 1, 0, 0, 0, "R4 before delay");
    expect_at(DLY + 2, 0, 1, 0, "R4 low-side on");
    tick(DLY + 2); ls_fallen = 1'b0; tick(2);

    // To high side, flag raised late
    pwm_cmd = 1'b1;
    expect_at(1, 0, 0, 0, "R5 low side dropped");
    tick(4);
    ls_fallen = 1'b1;
    expect_at(0, 0, 0, 0, "R3 waits for flag");
    expect_at(DLY, 0, 0, 0, "R3 before delay");
    expect_at(DLY + 1, 1, 0, 0, "R3 high-side on");
    tick(DLY + 1); hs_fallen = 1'b0; tick(2);

    // Back to low side
    pwm_cmd = 1'b0;
    expect_at(1, 0, 0, 0, "R5 high side dropped");
    tick(2);
    hs_fallen = 1'b1;
    expect_at(DLY, 0, 0, 0, "R4 before delay");
    expect_at(DLY + 1, 0, 1, 0, "R4 low-side on");
    tick(DLY + 1); ls_fallen = 1'b0; tick(2);

    // Reversal during the delay count
    pwm_cmd = 1'b1;
    tick(1); ls_fallen = 1'b1;
    tick(2); pwm_cmd = 1'b0;
    expect_at(3, 0, 0, 0, "R8 abandoned high-side edge");
    expect_at(5, 0, 0, 0, "R8 restart wait");
    expect_at(6, 0, 1, 0, "R8 restarted low side");
    tick(6); ls_fallen = 1'b0; tick(2);

    // Stuck flag: timeout
    pwm_cmd = 1'b1;
    expect_at(1, 0, 0, 0, "R5 low side dropped");
    expect_at(TMO, 0, 0, 0, "R9 still waiting");
    expect_at(TMO + 1, 0, 0, 1, "R9 fault raised");
    expect_at(TMO + DLY, 0, 0, 1, "R9 before delay");
    expect_at(TMO + DLY + 1, 1, 0, 1, "R9 high side after timeout");
    tick(TMO + DLY + 1); ls_fallen = 1'b1; hs_fallen = 1'b0; tick(2);

    // Clamp overrides high command
    force_ls = 1'b1;
    expect_at(1, 0, 0, 1, "R6 high side dropped");
    tick(3); hs_fallen = 1'b1;
    expect_at(DLY, 0, 0, 1, "R6 before delay");
    expect_at(DLY + 1, 0, 1, 1, "R6 clamp low side on");
    tick(DLY + 1); ls_fallen = 1'b0; tick(2);

    // Kill
    force_off = 1'b1;
    expect_at(1, 0, 0, 1, "R7 kill");
    expect_at(3, 0, 0, 1, "R7 kill held");
    tick(3);
    force_off = 1'b0; force_ls = 1'b0; ls_fallen = 1'b1;
    expect_at(DLY + 2, 1, 0, 1, "R10 full duty on");
    expect_at(20, 1, 0, 1, "R10 full duty held");
    expect_at(35, 1, 0, 1, "R10 full duty held");
    tick(36);

    // Zero duty
    hs_fallen = 1'b0; pwm_cmd = 1'b0;
    expect_at(1, 0, 0, 1, "R5 high side dropped");
    tick(1); hs_fallen = 1'b1;
    expect_at(DLY + 1, 0, 1, 1, "R10 zero duty on");
    expect_at(30, 0, 1, 1, "R10 zero duty held");
    tick(31);

    // Reset clears the fault
    rst = 1'b1;
    expect_at(1, 0, 0, 0, "R2 reset clears fault");
    tick(3);
    rst = 1'b0; force_off = 1'b1;
    tick(2);

    finished = 1'b1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending items expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule